// File: doc/BRIEF.md
# Indirect SDRAM Bank Configuration Unit

This block is the configuration and address-decode front end of a four-bank SDRAM controller. Software sees only two bus registers. One is an index port that selects an internal register. The other is a data port that reads or writes the register the index selects. The internal register file holds the controller configuration and a read-only status word. It also holds a refresh interval, a power-management timer, four bank descriptors, two bus-error status words, an error address, an ECC configuration and an ECC error syndrome.

Each bank descriptor places a power-of-two window of memory at an 8 MiB-aligned base. The decode side compares an incoming physical address with every active window. It reports the bank that claims the address as a one-hot vector, or it raises a miss flag. A single controller-enable bit gates every window at once. A nonzero ECC syndrome drives an interrupt line.

Top module: `sdcfg_unit`

## Requirements
- R1: A bus write with `bus_addr` 0x10 loads the 32-bit index, and a read at 0x10 returns the index. A bus access at 0x11 reads or writes the internal register the index selects. Reads at any other bus address return zero, and writes there change nothing. `bus_rdata` is combinational and is zero while `bus_sel` is low. A write takes effect at the rising edge of the cycle in which it is presented.
- R2: After a synchronous reset the registers hold these values: refresh (index 0x30) 0x05F00000, power-management (0x34) 0x07C00000, configuration (0x20) 0x00800000. The index, status (0x24), error words (0x00, 0x08), error address (0x10), banks (0x40, 0x44, 0x48, 0x4C), ECC configuration (0x94) and ECC syndrome (0x98) all hold zero.
- R3: In the error words at 0x00 and 0x08, each 1 bit written clears that bit. The error address at 0x10 stores the full written value. Writes to the status word at 0x24 are ignored. Reading index 0x80 returns 0xFFFFFFFF, and so does reading any index that names no register.
- R4: A configuration write keeps only bits 31:21. When bit 31 goes from 0 to 1, status bit 31 clears. When bit 31 goes from 1 to 0, status bit 31 sets. Status bit 30 takes the new value of configuration bit 30. All other status bits read zero.
- R5: A refresh write keeps bits 29:19. A power-management write keeps bits 31:27 and forces bits 26:22 to one. An ECC configuration write keeps bits 23:20.
- R6: A bank write stores the data ANDed with 0xFFDEE001. In a bank word, bits 31:23 are the base address bits 31:23, bits 19:17 are the size code, and bit 0 is the bank enable.
- R7: Bank n claims a physical address A when all of these hold: its enable bit is 1, configuration bit 31 is 1, and base <= A < base + (4 MiB << code). The decode is combinational on the stored registers.
- R8: `bank_hit` is one-hot. When windows overlap, the lowest-numbered claiming bank is reported. `bank_miss` is high exactly when no bank claims the address.
- R9: A bank whose size code is 7 never claims any address.
- R10: An ECC syndrome write stores the data ANDed with 0xFFF0F000. `ecc_irq` is high from the edge that makes the syndrome nonzero until the edge that makes it zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW (10) | Bus register number |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| phys_addr | input | 32 | Physical address to decode |
| bank_hit | output | NUM_BANKS (4) | One-hot claiming bank |
| bank_miss | output | 1 | No bank claims the address |
| ecc_irq | output | 1 | ECC syndrome is nonzero |

## Verification
A bank-descriptor write through the data port and a lookup that falls inside that bank can land in the same cycle. The bench provokes this by presenting a lookup address during the exact cycle in which the bus writes bank 0. The lookup result in that cycle must still reflect the old descriptor. In the following cycle it must reflect the new one, where an overlapping higher bank now wins. The same overlap of a controller-enable toggle with lookups is judged in the cycles on either side of the configuration write.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;

    localparam int DW   = 32;
    localparam int PA_W = 32;

    // internal register indices
    localparam logic [DW-1:0] OFF_ERR0  = 32'h00;
    localparam logic [DW-1:0] OFF_ERR1  = 32'h08;
    localparam logic [DW-1:0] OFF_EADR  = 32'h10;
    localparam logic [DW-1:0] OFF_CFG   = 32'h20;
    localparam logic [DW-1:0] OFF_STAT  = 32'h24;
    localparam logic [DW-1:0] OFF_RFSH  = 32'h30;
    localparam logic [DW-1:0] OFF_PWR   = 32'h34;
    localparam logic [DW-1:0] OFF_BANK0 = 32'h40;
    localparam logic [DW-1:0] OFF_TIME  = 32'h80;
    localparam logic [DW-1:0] OFF_ECFG  = 32'h94;
    localparam logic [DW-1:0] OFF_ESYN  = 32'h98;

    // write masks and forced bits
    localparam logic [DW-1:0] CFG_KEEP  = 32'hFFE0_0000;
    localparam logic [DW-1:0] RFSH_KEEP = 32'h3FF8_0000;
    localparam logic [DW-1:0] PWR_KEEP  = 32'hF800_0000;
    localparam logic [DW-1:0] PWR_FORCE = 32'h07C0_0000;
    localparam logic [DW-1:0] BANK_KEEP = 32'hFFDE_E001;
    localparam logic [DW-1:0] ECFG_KEEP = 32'h00F0_0000;
    localparam logic [DW-1:0] ESYN_KEEP = 32'hFFF0_F000;

    // reset values
    localparam logic [DW-1:0] CFG_RST   = 32'h0080_0000;
    localparam logic [DW-1:0] RFSH_RST  = 32'h05F0_0000;
    localparam logic [DW-1:0] PWR_RST   = 32'h07C0_0000;

    localparam logic [DW-1:0] READ_ONES = 32'hFFFF_FFFF;
    localparam logic [2:0]    CODE_BAD  = 3'd7;
    localparam logic [PA_W:0] BANK_UNIT = 33'h0_0040_0000;

    typedef enum logic [3:0] {
        SEL_ERR0, SEL_ERR1, SEL_EADR, SEL_CFG, SEL_STAT, SEL_RFSH,
        SEL_PWR, SEL_BANK, SEL_TIME, SEL_ECFG, SEL_ESYN, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [8:0]  base_hi;
        logic [2:0]  gap_a;
        logic [2:0]  size_code;
        logic [15:0] gap_b;
        logic        en;
    } bank_word_t;

    function automatic reg_sel_e classify(input logic [DW-1:0] idx, input int nbanks);
        reg_sel_e s;
        if (idx == OFF_ERR0)      s = SEL_ERR0;
        else if (idx == OFF_ERR1) s = SEL_ERR1;
        else if (idx == OFF_EADR) s = SEL_EADR;
        else if (idx == OFF_CFG)  s = SEL_CFG;
        else if (idx == OFF_STAT) s = SEL_STAT;
        else if (idx == OFF_RFSH) s = SEL_RFSH;
        else if (idx == OFF_PWR)  s = SEL_PWR;
        else if (idx == OFF_TIME) s = SEL_TIME;
        else if (idx == OFF_ECFG) s = SEL_ECFG;
        else if (idx == OFF_ESYN) s = SEL_ESYN;
        else if (idx >= OFF_BANK0 && idx < OFF_BANK0 + 32'(4 * nbanks) && idx[1:0] == 2'b00)
            s = SEL_BANK;
        else s = SEL_NONE;
        return s;
    endfunction

    function automatic logic [PA_W:0] bank_span(input logic [2:0] code);
        return BANK_UNIT << code;
    endfunction

endpackage

// File: rtl/sdcfg_regs.sv
module sdcfg_regs
    import sdcfg_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          idx_wr,
    input  logic                          win_wr,
    input  logic [DW-1:0]                 wdata,
    output logic [DW-1:0]                 rd_idx,
    output logic [DW-1:0]                 rd_win,
    output logic                          ctrl_en,
    output logic [NUM_BANKS-1:0][DW-1:0]  bank_q,
    output logic                          ecc_irq
);
    localparam int BNW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [DW-1:0] idx_q, err0_q, err1_q, eadr_q, cfg_q, rfsh_q, pwr_q, ecfg_q, esyn_q;
    logic [1:0]    stat_q;
    logic          irq_q;
    reg_sel_e      sel;
    logic [BNW-1:0] bnum;
    logic [DW-1:0] cfg_new, esyn_new;

    assign sel      = classify(idx_q, NUM_BANKS);
    assign bnum     = idx_q[2 +: BNW];
    assign cfg_new  = wdata & CFG_KEEP;
    assign esyn_new = wdata & ESYN_KEEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            err0_q <= '0;
            err1_q <= '0;
            eadr_q <= '0;
            cfg_q  <= CFG_RST;
            stat_q <= 2'b00;
            rfsh_q <= RFSH_RST;
            pwr_q  <= PWR_RST;
            ecfg_q <= '0;
            esyn_q <= '0;
            irq_q  <= 1'b0;
            bank_q <= '0;
        end else begin
            if (idx_wr) idx_q <= wdata;
            if (win_wr) begin
                case (sel)
                    SEL_ERR0: err0_q <= err0_q & ~wdata;
                    SEL_ERR1: err1_q <= err1_q & ~wdata;
                    SEL_EADR: eadr_q <= wdata;
                    SEL_CFG: begin
                        if (!cfg_q[31] && cfg_new[31])      stat_q[1] <= 1'b0;
                        else if (cfg_q[31] && !cfg_new[31]) stat_q[1] <= 1'b1;
                        stat_q[0] <= cfg_new[30];
                        cfg_q     <= cfg_new;
                    end
                    SEL_RFSH: rfsh_q <= wdata & RFSH_KEEP;
                    SEL_PWR:  pwr_q  <= (wdata & PWR_KEEP) | PWR_FORCE;
                    SEL_BANK: bank_q[bnum] <= wdata & BANK_KEEP;
                    SEL_ECFG: ecfg_q <= wdata & ECFG_KEEP;
                    SEL_ESYN: begin
                        esyn_q <= esyn_new;
                        irq_q  <= |esyn_new;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_ERR0: rd_win = err0_q;
            SEL_ERR1: rd_win = err1_q;
            SEL_EADR: rd_win = eadr_q;
            SEL_CFG:  rd_win = cfg_q;
            SEL_STAT: rd_win = {stat_q, 30'b0};
            SEL_RFSH: rd_win = rfsh_q;
            SEL_PWR:  rd_win = pwr_q;
            SEL_BANK: rd_win = bank_q[bnum];
            SEL_ECFG: rd_win = ecfg_q;
            SEL_ESYN: rd_win = esyn_q;
            default:  rd_win = READ_ONES;
        endcase
    end

    assign rd_idx  = idx_q;
    assign ctrl_en = cfg_q[31];
    assign ecc_irq = irq_q;

    // R4: enable transitions are mirrored in status bit 31
    assert_en_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_q[31]) |-> !stat_q[1]);
    assert_en_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_q[31]) |-> stat_q[1]);
    assert_stat30_R4: assert property (@(posedge clk) disable iff (rst)
        stat_q[0] == cfg_q[30]);
    // R5: forced power-management bits never drop
    assert_pwr_force_R5: assert property (@(posedge clk) disable iff (rst)
        pwr_q[26:22] == 5'h1F);
    // R10: interrupt tracks a nonzero syndrome
    assert_irq_track_R10: assert property (@(posedge clk) disable iff (rst)
        irq_q == (esyn_q != '0));

endmodule

// File: rtl/sdcfg_bank_match.sv
module sdcfg_bank_match
    import sdcfg_pkg::*;
(
    input  logic [DW-1:0]   bank_word,
    input  logic            ctrl_en,
    input  logic [PA_W-1:0] paddr,
    output logic            hit
);
    bank_word_t      bw;
    logic [PA_W:0]   lo, hi, a;
    logic            live;

    assign bw   = bank_word_t'(bank_word);
    assign lo   = {1'b0, bw.base_hi, 23'b0};
    assign hi   = lo + bank_span(bw.size_code);
    assign a    = {1'b0, paddr};
    assign live = bw.en && ctrl_en && (bw.size_code != CODE_BAD);
    assign hit  = live && (a >= lo) && (a < hi);
endmodule

// File: rtl/sdcfg_prio.sv
module sdcfg_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         none
);
    assign grant = req & (~req + N'(1));
    assign none  = ~|req;
endmodule

// File: rtl/sdcfg_unit.sv
module sdcfg_unit
    import sdcfg_pkg::*;
#(
    parameter int BUS_AW    = 10,
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [PA_W-1:0]      phys_addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output logic                 bank_miss,
    output logic                 ecc_irq
);
    localparam logic [BUS_AW-1:0] PORT_IDX  = BUS_AW'(16'h10);
    localparam logic [BUS_AW-1:0] PORT_DATA = BUS_AW'(16'h11);

    logic                         idx_wr, win_wr, ctrl_en;
    logic [DW-1:0]                rd_idx, rd_win;
    logic [NUM_BANKS-1:0][DW-1:0] bank_q;
    logic [NUM_BANKS-1:0]         raw_hit;

    assign idx_wr = bus_sel && bus_we && (bus_addr == PORT_IDX);
    assign win_wr = bus_sel && bus_we && (bus_addr == PORT_DATA);

    sdcfg_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk(clk), .rst(rst), .idx_wr(idx_wr), .win_wr(win_wr),
        .wdata(bus_wdata), .rd_idx(rd_idx), .rd_win(rd_win),
        .ctrl_en(ctrl_en), .bank_q(bank_q), .ecc_irq(ecc_irq)
    );

    always_comb begin
        if (!bus_sel)                   bus_rdata = '0;
        else if (bus_addr == PORT_IDX)  bus_rdata = rd_idx;
        else if (bus_addr == PORT_DATA) bus_rdata = rd_win;
        else                            bus_rdata = '0;
    end

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        sdcfg_bank_match u_match (
            .bank_word(bank_q[i]), .ctrl_en(ctrl_en),
            .paddr(phys_addr), .hit(raw_hit[i])
        );
        // R9: a reserved size code never claims
        assert_code7_R9: assert property (@(posedge clk) disable iff (rst)
            (bank_q[i][19:17] == 3'd7) |-> !bank_hit[i]);
    end

    sdcfg_prio #(.N(NUM_BANKS)) u_prio (
        .req(raw_hit), .grant(bank_hit), .none(bank_miss)
    );

    // R8: single winner, miss exactly when none
    assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_hit) && (bank_miss == (bank_hit == '0)));
    // R7: nothing claims while the controller is off
    assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (|bank_hit) |-> ctrl_en);

endmodule

// File: tb/sim_sdcfg_unit.sv
module sim_sdcfg_unit;
    localparam int AW = 10;
    localparam logic [AW-1:0] PI = 10'h010;
    localparam logic [AW-1:0] PD = 10'h011;

    logic clk = 1'b0;
    logic rst;
    logic bus_sel, bus_we;
    logic [AW-1:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata, phys_addr;
    logic [3:0] bank_hit;
    logic bank_miss, ecc_irq;

    always #4 clk = ~clk;   // 125 MHz

    sdcfg_unit u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .phys_addr(phys_addr), .bank_hit(bank_hit), .bank_miss(bank_miss),
        .ecc_irq(ecc_irq)
    );

    typedef struct {
        int          kind;   // 0 rdata, 1 {miss,hit}, 2 irq
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // monitor: compares queued expectations mid low phase
    always @(negedge clk) begin
        #2;
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = bus_rdata;
                1: act = {27'b0, bank_miss, bank_hit};
                default: act = {31'b0, ecc_irq};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input int k, input logic [31:0] e, input string t);
        item_t it;
        it.kind = k; it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask

    task automatic drive(input logic s, input logic w, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [31:0] idx, input logic [31:0] d);
        drive(1, 1, PI, idx);
        drive(1, 1, PD, d);
    endtask

    task automatic rd(input logic [31:0] idx, input logic [31:0] e, input string t);
        drive(1, 1, PI, idx);
        drive(1, 0, PD, 32'h0);
        push(0, e, t);
    endtask

    task automatic look(input logic [31:0] pa, input logic [4:0] e, input string t);
        drive(0, 0, '0, 32'h0);
        phys_addr = pa;
        push(1, {27'b0, e}, t);
    endtask

    task automatic irq_chk(input logic e, input string t);
        drive(0, 0, '0, 32'h0);
        push(2, {31'b0, e}, t);
    endtask

    localparam logic [4:0] MISS = 5'b10000;

    initial begin
        rst = 1'b1; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; phys_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        drive(1, 0, PI, 0); push(0, 32'h0, "R2 index");
        rd(32'h30, 32'h05F00000, "R2 refresh");
        rd(32'h34, 32'h07C00000, "R2 power");
        rd(32'h20, 32'h00800000, "R2 config");
        rd(32'h24, 32'h0, "R2 status");
        rd(32'h40, 32'h0, "R2 bank0");
        rd(32'h98, 32'h0, "R2 syndrome");
        irq_chk(0, "R2 irq");
        look(32'h100, MISS, "R2 no bank");

        // R1 bus ports
        drive(1, 1, PI, 32'h0000_0094);
        drive(1, 1, 10'h005, 32'hDEAD_BEEF);
        drive(1, 0, PI, 0); push(0, 32'h94, "R1 index kept");
        drive(1, 0, 10'h012, 0); push(0, 32'h0, "R1 other port");
        drive(0, 0, PI, 0); push(0, 32'h0, "R1 idle rdata");

        // R5 masks
        wr(32'h30, 32'hFFFF_FFFF); rd(32'h30, 32'h3FF80000, "R5 refresh");
        wr(32'h34, 32'h0);         rd(32'h34, 32'h07C00000, "R5 power force");
        wr(32'h34, 32'hFFFF_FFFF); rd(32'h34, 32'hFFC00000, "R5 power keep");
        wr(32'h94, 32'hFFFF_FFFF); rd(32'h94, 32'h00F00000, "R5 ecc cfg");

        // R3
        wr(32'h00, 32'hFFFF_FFFF); rd(32'h00, 32'h0, "R3 err0");
        wr(32'h08, 32'hFFFF_FFFF); rd(32'h08, 32'h0, "R3 err1");
        wr(32'h24, 32'hFFFF_FFFF); rd(32'h24, 32'h0, "R3 status ro");
        wr(32'h10, 32'h1234_5678); rd(32'h10, 32'h12345678, "R3 err addr");
        wr(32'h80, 32'h0);         rd(32'h80, 32'hFFFFFFFF, "R3 timing");
        rd(32'h0C, 32'hFFFFFFFF, "R3 unknown");

        // R6 bank masks and layout
        wr(32'h40, 32'hFFFF_FFFF); rd(32'h40, 32'hFFDEE001, "R6 bank mask");
        wr(32'h40, 32'h0002_0001);
        wr(32'h44, 32'h0080_0001);
        wr(32'h48, 32'h0004_0001);
        wr(32'h4C, 32'h400E_0001);
        rd(32'h4C, 32'h400E0001, "R6 bank3");
        look(32'h100, MISS, "R7 controller off");

        // R4 enable
        wr(32'h20, 32'h80FF_FFFF); rd(32'h20, 32'h80E00000, "R4 cfg mask");
        rd(32'h24, 32'h0, "R4 status on");
        look(32'h0000_0100, 5'b00001, "R8 overlap low bank");
        look(32'h007F_FFFF, 5'b00001, "R7 bank0 top");
        look(32'h0080_0000, 5'b00010, "R8 bank1 over bank2");
        look(32'h00C0_0000, 5'b00100, "R7 bank2 only");
        look(32'h0100_0000, MISS, "R7 past all");
        look(32'h4000_0000, MISS, "R9 code7");
        wr(32'h4C, 32'h400C_0001);
        look(32'h4000_0000, 5'b01000, "R7 bank3 base");
        look(32'h4FFF_FFFF, 5'b01000, "R7 bank3 end");
        look(32'h5000_0000, MISS, "R7 bank3 beyond");
        wr(32'h44, 32'h0080_0000);
        look(32'h0080_0000, 5'b00100, "R7 bank1 disabled");

        wr(32'h20, 32'h4000_0000);
        rd(32'h24, 32'hC0000000, "R4 status off");
        look(32'h100, MISS, "R4 all banks off");
        wr(32'h20, 32'h8000_0000);
        rd(32'h24, 32'h0, "R4 status back on");
        look(32'h100, 5'b00001, "R4 banks restored");

        // same cycle: bank0 write with a lookup in bank0
        drive(1, 1, PI, 32'h40);
        drive(1, 1, PD, 32'h1000_0001);
        phys_addr = 32'h100;
        push(1, {27'b0, 5'b00001}, "R7 old bank0 during write");
        look(32'h100, 5'b00100, "R8 new winner after write");

        // R10
        wr(32'h98, 32'hFFFF_FFFF);
        irq_chk(1, "R10 irq rise");
        rd(32'h98, 32'hFFF0F000, "R10 mask");
        wr(32'h98, 32'h000F_0FFF);
        irq_chk(0, "R10 irq fall");
        rd(32'h98, 32'h0, "R10 cleared");

        drive(0, 0, '0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule